// File: doc/BRIEF.md
# Three-Level Priority Interrupt Arbiter

This block picks one interrupt to deliver out of thirteen request sources and presents that interrupt's vector address to the processor core. Every source has its own enable bit, and a global enable gates all of them. Twelve of the sources can be placed at a high or a low level by software. The power-fail source is fixed at a third level above both of those. Among enabled pending requests, the highest level wins. Within one level, a fixed natural order breaks ties.

The two serial-port sources are not wired in directly. Each is formed as the OR of that port's transmit and receive flags. The arbiter keeps a mask of the levels currently in service. A request is offered only when its level is strictly above every level in that mask, so a higher level can preempt a lower one, but a request never preempts its own level.

Delivery uses a valid/ack handshake. The winner's vector is latched and held stable until the core acknowledges it. The acknowledge marks the winner's level as in service. A return strobe retires the highest level in service.

The control state machine has two states:
- `S_IDLE`: no offer is outstanding, and the arbiter evaluates candidates every cycle.
- `S_OFFER`: the vector is latched and valid is high.

It has two transitions:
- `S_IDLE -> S_OFFER`: taken when an eligible candidate exists at a clock edge.
- `S_OFFER -> S_IDLE`: taken on an acknowledge.

Otherwise each state holds.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `vec_valid_o` is 0 and `insvc_o` is 3'b000.
- R2: Source indices in natural order run from 0 to 12:
  - 0 power-fail, 1 ext0, 2 timer0, 3 ext1, 4 timer1, 5 serial0, 6 timer2.
  - 7 serial1, 8 ext2, 9 ext3, 10 ext4, 11 ext5, 12 watchdog.
  - Their vectors are 33h, 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 3Bh, 43h, 4Bh, 53h, 5Bh and 63h respectively.
  - `line_req_i` carries the eleven non-serial sources in ascending index order, skipping 5 and 7.
- R3: Source 5 requests when `ser_tx_i[0]` or `ser_rx_i[0]` is high. Source 7 requests when `ser_tx_i[1]` or `ser_rx_i[1]` is high.
- R4: Levels are encoded as 0 for low, 1 for high and 2 for power-fail. The high level (`src_hi_i[i]`=1) beats the low level regardless of natural order. Power-fail is always level 2, and `src_hi_i[0]` is ignored.
- R5: Within one level, the pending source with the lowest index wins.
- R6: A source whose `src_en_i` bit is 0 is never offered. No source is offered while `gbl_en_i` is 0.
- R7: `vec_valid_o` rises one clock edge after an eligible request is sampled in `S_IDLE`. While valid is high and ack is low, `vec_o` and valid stay unchanged, even if requests change.
- R8: An ack while valid is high sets bit `level` of `insvc_o` and drops `vec_valid_o` at the same edge.
- R9: A request is offered only if no `insvc_o` bit at its own level or above is set.
- R10: A return strobe clears only the highest set bit of `insvc_o`. Neither a return with nothing in service nor an ack with no offer outstanding has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gbl_en_i | input | 1 | Global enable for all sources |
| src_en_i | input | 13 | Per-source enable, bit = source index |
| src_hi_i | input | 13 | Per-source high-level select (bit 0 ignored) |
| line_req_i | input | 11 | Requests of the non-serial sources |
| ser_tx_i | input | 2 | Transmit flags of serial ports 0 and 1 |
| ser_rx_i | input | 2 | Receive flags of serial ports 0 and 1 |
| ack_i | input | 1 | Core accepts the offered vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_valid_o | output | 1 | A vector is offered |
| vec_o | output | 8 | Vector address of the offered source |
| insvc_o | output | 3 | In-service mask, bit = level |

## Verification
Each result is due at a fixed edge:
- A new offer is due one rising edge after the request is presented in `S_IDLE`.
- An acknowledge updates `insvc_o` and drops valid at the very edge that samples it.
- After an ack or a return, the arbiter re-evaluates at the following edge, so a previously blocked request appears one edge after that.

The bench drives inputs 1 ns after a rising edge and samples 1 ns after the edge where each result is due. It also samples before that edge where the requirement says nothing must change yet.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NSRC  = 13;
    localparam int NLINE = NSRC - 2;
    localparam int NLVL  = 3;
    localparam int IDX_W = $clog2(NSRC);
    localparam int LVL_W = $clog2(NLVL);
    localparam int VEC_W = 8;
    localparam int PF    = 0;
    localparam int SER0  = 5;
    localparam int SER1  = 7;

    typedef enum logic [LVL_W-1:0] {
        LVL_LO = 2'd0,
        LVL_HI = 2'd1,
        LVL_PF = 2'd2
    } lvl_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } arb_st_e;

    // Vectors are spaced 8 apart; power-fail takes slot 6 and the
    // sources after timer2 skip past it.
    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] slot;
        if (idx == '0)
            slot = IDX_W'(6);
        else if (idx < IDX_W'(7))
            slot = idx - IDX_W'(1);
        else
            slot = idx;
        return VEC_W'(3) + {1'b0, slot, 3'b000};
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import prio_irq_pkg::*;
(
    input  logic [NLINE-1:0] line_req_i,
    input  logic [1:0]       ser_tx_i,
    input  logic [1:0]       ser_rx_i,
    output logic [NSRC-1:0]  req_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == SER0) begin : g_ser0
            assign req_o[i] = ser_tx_i[0] | ser_rx_i[0];
        end else if (i == SER1) begin : g_ser1
            assign req_o[i] = ser_tx_i[1] | ser_rx_i[1];
        end else begin : g_line
            localparam int LI = i - ((i > SER0) ? 1 : 0) - ((i > SER1) ? 1 : 0);
            assign req_o[i] = line_req_i[LI];
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Lowest index wins: scan downward so the last hit is the lowest.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend_i[k]) begin
                any_o = 1'b1;
                idx_o = IW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_insvc.sv
module irq_insvc
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [LVL_W-1:0] set_lvl_i,
    input  logic             clr_i,
    output logic [NLVL-1:0]  mask_o
);

    logic [NLVL-1:0] mask_q;
    logic [NLVL-1:0] top;
    logic [NLVL-1:0] mask_d;

    always_comb begin
        top = '0;
        for (int k = 0; k < NLVL; k++) begin
            if (mask_q[k]) begin
                top    = '0;
                top[k] = 1'b1;
            end
        end
    end

    always_comb begin
        mask_d = mask_q & ~(clr_i ? top : '0);
        if (set_i)
            mask_d[set_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    assert_set_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> mask_o[$past(set_lvl_i)]);

    assert_ret_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && (mask_o != '0)) |=>
            ($countones(mask_o) == $countones($past(mask_o)) - 1));

    assert_ret_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && (mask_o == '0)) |=> (mask_o == '0));

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gbl_en_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic [NSRC-1:0]   src_hi_i,
    input  logic [NLINE-1:0]  line_req_i,
    input  logic [1:0]        ser_tx_i,
    input  logic [1:0]        ser_rx_i,
    input  logic              ack_i,
    input  logic              reti_i,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [NLVL-1:0]   insvc_o
);

    arb_st_e          st, st_nx;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  hi_eff;
    logic [NSRC-1:0]  lvl_pend [NLVL];
    logic [NLVL-1:0]  pick_any;
    logic [IDX_W-1:0] pick_idx [NLVL];
    logic [NLVL-1:0]  blk;
    logic             cand_ok;
    lvl_e             cand_lvl;
    logic [IDX_W-1:0] cand_idx;
    lvl_e             lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             take;

    irq_src_map u_map (
        .line_req_i (line_req_i),
        .ser_tx_i   (ser_tx_i),
        .ser_rx_i   (ser_rx_i),
        .req_o      (req)
    );

    assign pend   = req & src_en_i & {NSRC{gbl_en_i}};
    assign hi_eff = src_hi_i & ~(NSRC'(1) << PF);

    // Split pending requests by level; power-fail is pinned to the top.
    always_comb begin
        logic [LVL_W-1:0] sl;
        for (int l = 0; l < NLVL; l++)
            lvl_pend[l] = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (s == PF)
                sl = LVL_PF;
            else
                sl = hi_eff[s] ? LVL_HI : LVL_LO;
            lvl_pend[sl][s] = pend[s];
        end
    end

    for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
        irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
            .pend_i (lvl_pend[gl]),
            .any_o  (pick_any[gl]),
            .idx_o  (pick_idx[gl])
        );
    end

    // A level is blocked while it or any level above it is in service.
    always_comb begin
        for (int l = 0; l < NLVL; l++)
            blk[l] = |(insvc_o >> l);
    end

    always_comb begin
        cand_ok  = 1'b0;
        cand_lvl = LVL_LO;
        cand_idx = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (pick_any[l] && !blk[l]) begin
                cand_ok  = 1'b1;
                cand_lvl = lvl_e'(LVL_W'(l));
                cand_idx = pick_idx[l];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (cand_ok) st_nx = S_OFFER;
            S_OFFER: if (ack_i)   st_nx = S_IDLE;
        endcase
    end

    // Winner latch: loaded only on entry to S_OFFER
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= LVL_LO;
        end else if (st == S_IDLE && cand_ok) begin
            vec_q <= src_vector(cand_idx);
            lvl_q <= cand_lvl;
        end
    end

    // Outputs
    always_comb begin
        vec_valid_o = (st == S_OFFER);
        vec_o       = vec_q;
        take        = (st == S_OFFER) && ack_i;
    end

    irq_insvc u_insvc (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take),
        .set_lvl_i (lvl_q),
        .clr_i     (reti_i),
        .mask_o    (insvc_o)
    );

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !ack_i) |=> (vec_valid_o && $stable(vec_o)));

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && ack_i) |=> !vec_valid_o);

    assert_above_insvc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ((insvc_o >> lvl_q) == '0));

    assert_gbl_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid_o && !gbl_en_i) |=> !vec_valid_o);

endmodule

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gbl_en = 1'b0;
    logic [12:0] src_en = '0;
    logic [12:0] src_hi = '0;
    logic [10:0] line_req = '0;
    logic [1:0]  ser_tx = '0;
    logic [1:0]  ser_rx = '0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        vec_valid;
    logic [7:0]  vec;
    logic [2:0]  insvc;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_prio_arb uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .gbl_en_i   (gbl_en),
        .src_en_i   (src_en),
        .src_hi_i   (src_hi),
        .line_req_i (line_req),
        .ser_tx_i   (ser_tx),
        .ser_rx_i   (ser_rx),
        .ack_i      (ack),
        .reti_i     (reti),
        .vec_valid_o(vec_valid),
        .vec_o      (vec),
        .insvc_o    (insvc)
    );

    typedef struct packed {
        logic [12:0] src;
        logic [1:0]  tx;
        logic [1:0]  rx;
        logic [12:0] en;
        logic [12:0] hi;
        logic        ev;
        logic [7:0]  vec;
        logic [1:0]  lvl;
    } case_t;

    localparam int NCASE = 17;
    localparam case_t TBL [NCASE] = '{
        '{13'h0002, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h03, 2'd0}, // R2 ext0
        '{13'h1000, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h63, 2'd0}, // R2 watchdog
        '{13'h1002, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h03, 2'd0}, // R5
        '{13'h1002, 2'b00, 2'b00, 13'h1FFF, 13'h1000, 1'b1, 8'h63, 2'd1}, // R4 high beats order
        '{13'h1003, 2'b00, 2'b00, 13'h1FFF, 13'h1000, 1'b1, 8'h33, 2'd2}, // R4 power-fail top
        '{13'h0001, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h33, 2'd2}, // R4 hi bit 0 ignored
        '{13'h0000, 2'b01, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h23, 2'd0}, // R3 serial0 tx
        '{13'h0000, 2'b00, 2'b10, 13'h1FFF, 13'h0000, 1'b1, 8'h3B, 2'd0}, // R3 serial1 rx
        '{13'h0100, 2'b00, 2'b00, 13'h1EFF, 13'h0000, 1'b0, 8'h00, 2'd0}, // R6 masked
        '{13'h0900, 2'b00, 2'b00, 13'h1FFF, 13'h0800, 1'b1, 8'h5B, 2'd1}, // R4 ext5 high
        '{13'h0440, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h2B, 2'd0}, // R5 timer2
        '{13'h0010, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h1B, 2'd0}, // R2 timer1
        '{13'h0004, 2'b00, 2'b00, 13'h1FFF, 13'h0000, 1'b1, 8'h0B, 2'd0}, // R2 timer0
        '{13'h0208, 2'b00, 2'b00, 13'h1FFF, 13'h0200, 1'b1, 8'h4B, 2'd1}, // R4 ext3 high
        '{13'h0000, 2'b01, 2'b00, 13'h1FDF, 13'h0000, 1'b0, 8'h00, 2'd0}, // R6 serial0 masked
        '{13'h1000, 2'b10, 2'b00, 13'h1FFF, 13'h1000, 1'b1, 8'h63, 2'd1}, // R4 wd high over serial1
        '{13'h0018, 2'b00, 2'b00, 13'h1FF7, 13'h0000, 1'b1, 8'h1B, 2'd0}  // R6 ext1 masked
    };

    function automatic logic [10:0] to_line(input logic [12:0] s);
        logic [10:0] r;
        int j;
        r = '0;
        j = 0;
        for (int i = 0; i < 13; i++) begin
            if (i != 5 && i != 7) begin
                r[j] = s[i];
                j++;
            end
        end
        return r;
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [12:0] s, input logic [1:0] tx, input logic [1:0] rx,
                         input logic [12:0] en, input logic [12:0] hi);
        line_req = to_line(s);
        ser_tx   = tx;
        ser_rx   = rx;
        src_en   = en;
        src_hi   = hi;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        tick();
        reti = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        drive(13'h0002, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        gbl_en = 1'b1;
        repeat (3) tick();
        chk("R1", "valid in reset", int'(vec_valid), 0);
        chk("R1", "insvc in reset", int'(insvc), 0);
        drive(13'h0000, 2'b00, 2'b00, 13'h0000, 13'h0000);
        rst_n = 1'b1;
        #1;
        chk("R1", "valid after reset", int'(vec_valid), 0);
        chk("R1", "insvc after reset", int'(insvc), 0);
        tick();

        // Table walk
        for (int c = 0; c < NCASE; c++) begin
            drive(TBL[c].src, TBL[c].tx, TBL[c].rx, TBL[c].en, TBL[c].hi);
            chk("R7", "valid before edge", int'(vec_valid), 0);
            tick();
            chk("R2 R4 R5 R6", $sformatf("case %0d valid", c), int'(vec_valid), int'(TBL[c].ev));
            if (TBL[c].ev) begin
                chk("R2", $sformatf("case %0d vector", c), int'(vec), int'(TBL[c].vec));
                do_ack();
                chk("R8", $sformatf("case %0d insvc", c), int'(insvc), 1 << TBL[c].lvl);
                chk("R8", $sformatf("case %0d valid drop", c), int'(vec_valid), 0);
                drive(13'h0000, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
                do_reti();
                chk("R10", $sformatf("case %0d insvc cleared", c), int'(insvc), 0);
            end else begin
                drive(13'h0000, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
                tick();
            end
        end

        // R6: global enable low blocks everything
        gbl_en = 1'b0;
        drive(13'h0003, 2'b11, 2'b11, 13'h1FFF, 13'h1FFF);
        repeat (3) begin
            tick();
            chk("R6", "global disable valid", int'(vec_valid), 0);
        end
        gbl_en = 1'b1;
        tick();
        chk("R6", "global enable valid", int'(vec_valid), 1);
        chk("R6", "global enable vector", int'(vec), 'h33);
        do_ack();
        drive(13'h0000, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        do_reti();

        // R9: nesting
        drive(13'h0002, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        tick();
        chk("R9", "ext0 vector", int'(vec), 'h03);
        do_ack();
        chk("R9", "insvc low", int'(insvc), 3'b001);
        drive(13'h000A, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        repeat (3) begin
            tick();
            chk("R9", "same level blocked", int'(vec_valid), 0);
        end
        drive(13'h000E, 2'b00, 2'b00, 13'h1FFF, 13'h0004);
        tick();
        chk("R9", "high preempts low valid", int'(vec_valid), 1);
        chk("R9", "high preempts low vector", int'(vec), 'h0B);
        do_ack();
        chk("R9", "insvc low+high", int'(insvc), 3'b011);
        drive(13'h000F, 2'b00, 2'b00, 13'h1FFF, 13'h0004);
        tick();
        chk("R9", "power-fail preempts vector", int'(vec), 'h33);
        do_ack();
        chk("R9", "insvc all", int'(insvc), 3'b111);
        drive(13'h0000, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        do_reti();
        chk("R10", "reti clears top", int'(insvc), 3'b011);
        do_reti();
        chk("R10", "reti clears high", int'(insvc), 3'b001);
        drive(13'h0008, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        tick();
        chk("R9", "still blocked by low", int'(vec_valid), 0);
        do_reti();
        chk("R10", "reti clears low", int'(insvc), 3'b000);
        tick();
        chk("R9", "unblocked valid", int'(vec_valid), 1);
        chk("R9", "unblocked vector", int'(vec), 'h13);

        // R7: held while unacknowledged, even when requests change
        drive(13'h0001, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        repeat (3) begin
            tick();
            chk("R7", "held valid", int'(vec_valid), 1);
            chk("R7", "held vector", int'(vec), 'h13);
        end
        do_ack();
        chk("R8", "insvc low after held", int'(insvc), 3'b001);
        tick();
        chk("R7", "next winner vector", int'(vec), 'h33);
        do_ack();
        chk("R8", "insvc low+pf", int'(insvc), 3'b101);
        drive(13'h0000, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        do_reti();
        chk("R10", "reti skips empty middle", int'(insvc), 3'b001);
        do_reti();
        chk("R10", "reti to empty", int'(insvc), 3'b000);

        // R10: stray strobes have no effect
        do_ack();
        chk("R10", "ack without offer insvc", int'(insvc), 0);
        chk("R10", "ack without offer valid", int'(vec_valid), 0);
        do_reti();
        chk("R10", "reti with empty mask", int'(insvc), 0);
        drive(13'h0004, 2'b00, 2'b00, 13'h1FFF, 13'h0000);
        tick();
        chk("R10", "arbiter still live vector", int'(vec), 'h0B);

        summary();
        $finish;
    end

endmodule